// File: doc/BRIEF.md
# Cascadable Universal Interrupt Controller

A 32-source interrupt controller for a processor subsystem. Each source is configured on its own as level-sensitive or edge-triggered, and as active-high/rising or active-low/falling. Detected events latch into a pending register. An enable register gates the pending register to form a masked view. A routing register sends each masked source either to a normal interrupt line or to a critical interrupt line. Software reaches all registers through a simple synchronous write port with a combinational read.

Sources are numbered from the most significant bit down: source n is input `irq_i[31-n]` and register bit 31-n. Controllers cascade by wiring a child's interrupt line into one input bit of a parent. The handler then acknowledges the event in the child and also at the parent's cascade bit.

Top module: `casc_intc`

## Requirements
- R1: While reset is active, and right after it is released, every register (pending, enable, route, polarity, trigger) reads zero and both `irq_o` and `crit_o` are low. This holds as long as no source is at its active level.
- R2: The register addresses are 0 pending, 1 enable, 2 route, 3 polarity, 4 trigger and 5 masked. Address 5 is read-only, and a write to it changes nothing. Addresses 6 and 7 read zero. Source n corresponds to `irq_i[31-n]` and to bit 31-n of every register.
- R3: A write to address 0 clears each pending bit whose write-data bit is 1 and leaves the rest unchanged. Writing all ones clears every pending bit.
- R4: With trigger bit 0 (level), the pending bit is set on every clock while the input is at its active level, so a clear during that time has no lasting effect.
- R5: With trigger bit 1 (edge), the pending bit is set on the first clock edge after the active transition. It stays set after the input returns, until software clears it. A steady active level sets nothing further.
- R6: Polarity bit 1 selects high level or rising edge. Polarity bit 0 selects low level or falling edge. A transition of the wrong direction sets nothing.
- R7: Address 5 reads pending AND enable. A disabled source still latches pending but never raises an output.
- R8: A masked source whose route bit is 0 drives `irq_o`, and one whose route bit is 1 drives `crit_o`. Both outputs are registered one clock after the masked state and the route setting.
- R9: When a set and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: When a child's `irq_o` feeds an edge-triggered parent input, clearing the child alone leaves the parent's `irq_o` asserted. Clearing the parent's cascade bit as well drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| irq_i | input | 32 | Raw interrupt sources, source n on bit 31-n |
| irq_o | output | 1 | Normal interrupt line |
| crit_o | output | 1 | Critical interrupt line |

## Verification
Every cycle, the checker confirms four things: a pending bit drops only through a software clear; a clear removes every written bit that no new event sets at that moment; a concurrent set survives a clear; and an active level source stays pending. It also confirms that no output rises while the masked state is empty. The bench scenarios show the rest: polarity and edge direction, edge stickiness and the lack of re-triggering at a steady level, the one-cycle output latency, route switching between the two lines, read-only and unmapped addresses, and the two-level acknowledge of a cascade.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 3;

  typedef enum logic [AW-1:0] {
    A_STAT = 3'd0,
    A_ENAB = 3'd1,
    A_CRIT = 3'd2,
    A_POL  = 3'd3,
    A_TRIG = 3'd4,
    A_MASK = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/casc_intc_detect.sv
module casc_intc_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] set_o,
  output logic [N-1:0] act_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    logic lvl, edg;
    always_comb begin
      lvl      = pol_i[g] ? irq_i[g] : ~irq_i[g];
      edg      = pol_i[g] ? (irq_i[g] & ~prev_q[g]) : (~irq_i[g] & prev_q[g]);
      set_o[g] = trig_i[g] ? edg : lvl;
      act_o[g] = lvl;
    end
  end
endmodule

// File: rtl/casc_intc_regs.sv
module casc_intc_regs
  import casc_intc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  set_i,
  output logic [N-1:0]  rdata_o,
  output logic [N-1:0]  sr_o,
  output logic [N-1:0]  er_o,
  output logic [N-1:0]  cr_o,
  output logic [N-1:0]  pr_o,
  output logic [N-1:0]  tr_o,
  output logic [N-1:0]  msr_o
);
  logic [N-1:0] sr_q, er_q, cr_q, pr_q, tr_q, clr;

  function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
    return a == AW'(r);
  endfunction

  assign clr = (we_i && hit(addr_i, A_STAT)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; er_q <= '0; cr_q <= '0; pr_q <= '0; tr_q <= '0;
    end else begin
      sr_q <= (sr_q & ~clr) | set_i;  // set wins
      if (we_i && hit(addr_i, A_ENAB)) er_q <= wdata_i;
      if (we_i && hit(addr_i, A_CRIT)) cr_q <= wdata_i;
      if (we_i && hit(addr_i, A_POL))  pr_q <= wdata_i;
      if (we_i && hit(addr_i, A_TRIG)) tr_q <= wdata_i;
    end
  end

  assign msr_o = sr_q & er_q;

  always_comb begin
    rdata_o = '0;
    if      (hit(addr_i, A_STAT)) rdata_o = sr_q;
    else if (hit(addr_i, A_ENAB)) rdata_o = er_q;
    else if (hit(addr_i, A_CRIT)) rdata_o = cr_q;
    else if (hit(addr_i, A_POL))  rdata_o = pr_q;
    else if (hit(addr_i, A_TRIG)) rdata_o = tr_q;
    else if (hit(addr_i, A_MASK)) rdata_o = msr_o;
  end

  assign sr_o = sr_q;
  assign er_o = er_q;
  assign cr_o = cr_q;
  assign pr_o = pr_q;
  assign tr_o = tr_q;
endmodule

// File: rtl/casc_intc_merge.sv
module casc_intc_merge #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] msr_i,
  input  logic [N-1:0] cr_i,
  output logic         irq_o,
  output logic         crit_o
);
  logic irq_q, crit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      crit_q <= 1'b0;
    end else begin
      irq_q  <= |(msr_i & ~cr_i);
      crit_q <= |(msr_i & cr_i);
    end
  end

  assign irq_o  = irq_q;
  assign crit_o = crit_q;
endmodule

// File: rtl/casc_intc.sv
module casc_intc
  import casc_intc_pkg::*;
#(
  parameter int unsigned N_SRC  = NSRC,
  parameter int unsigned ADDR_W = AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  input  logic [N_SRC-1:0]  irq_i,
  output logic              irq_o,
  output logic              crit_o
);
  logic [N_SRC-1:0] sr_q, er_q, cr_q, pr_q, tr_q, msr, set_v, act_v;

  casc_intc_detect #(.N(N_SRC)) u_detect (
    .clk_i, .rst_ni, .irq_i,
    .pol_i(pr_q), .trig_i(tr_q), .set_o(set_v), .act_o(act_v)
  );

  casc_intc_regs #(.N(N_SRC), .AW(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .set_i(set_v), .rdata_o,
    .sr_o(sr_q), .er_o(er_q), .cr_o(cr_q), .pr_o(pr_q), .tr_o(tr_q), .msr_o(msr)
  );

  casc_intc_merge #(.N(N_SRC)) u_merge (
    .clk_i, .rst_ni, .msr_i(msr), .cr_i(cr_q), .irq_o, .crit_o
  );
endmodule

// File: rtl/casc_intc_chk.sv
module casc_intc_chk
  import casc_intc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  sr_q,
  input logic [N-1:0]  er_q,
  input logic [N-1:0]  tr_q,
  input logic [N-1:0]  set_v,
  input logic [N-1:0]  act_v,
  input logic          irq_o,
  input logic          crit_o
);
  logic stat_wr;
  assign stat_wr = we_i && (addr_i == AW'(A_STAT));

  // R3
  sr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> ((sr_q & $past(wdata_i & ~set_v)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && |(wdata_i & set_v)) |=>
      ((sr_q & $past(wdata_i & set_v)) == $past(wdata_i & set_v)));

  // R5
  sr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> (($past(sr_q) & ~sr_q) == '0));

  // R4
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(act_v & ~tr_q)) |=> ((sr_q & $past(act_v & ~tr_q)) == $past(act_v & ~tr_q)));

  // R7
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sr_q & er_q) == '0) |=> (!irq_o && !crit_o));
endmodule

bind casc_intc casc_intc_chk #(.N(N_SRC), .AW(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .sr_q(sr_q), .er_q(er_q), .tr_q(tr_q), .set_v(set_v), .act_v(act_v),
  .irq_o(irq_o), .crit_o(crit_o)
);

// File: tb/casc_intc_bench.sv
`timescale 1ns/1ps
module casc_intc_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        we = 0, pwe = 0;
  logic [2:0]  addr = 0, paddr = 0;
  logic [31:0] wdata = 0, pwdata = 0, rdata, prdata;
  logic [31:0] irq = 32'hFFFF_FFFF;
  logic        c_irq, c_crit, p_irq, p_crit;
  logic [31:0] p_in;
  int tests = 0, fails = 0;

  assign p_in = {c_irq, 31'h7FFF_FFFF};

  casc_intc u_casc_intc (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .irq_o(c_irq), .crit_o(c_crit));

  casc_intc u_parent (.clk_i(clk), .rst_ni(rst_n), .we_i(pwe), .addr_i(paddr),
    .wdata_i(pwdata), .rdata_o(prdata), .irq_i(p_in), .irq_o(p_irq), .crit_o(p_crit));

  localparam logic [2:0] STAT = 0, ENAB = 1, CRIT = 2, POL = 3, TRIG = 4, MASK = 5;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic pwr(input logic [2:0] a, input logic [31:0] d);
    pwe = 1; paddr = a; pwdata = d;
    @(negedge clk);
    pwe = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic prd(input logic [2:0] a, output logic [31:0] d);
    paddr = a; #0.5; d = prdata;
  endtask

  task automatic cfg(input logic [31:0] er, cr, pr, tr);
    wr(POL, pr); wr(TRIG, tr); wr(CRIT, cr); wr(STAT, 32'hFFFF_FFFF); wr(ENAB, er);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    step(2);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reg in reset", v, 0);
    end
    rst_n = 1;
    step();
    rd(STAT, v); check("R1 pending after release", v, 0);
    rd(ENAB, v); check("R1 enable after release", v, 0);
    check("R1 outputs", {30'b0, c_irq, c_crit}, 0);
    // default polarity 0 + level: low inputs become pending
    irq = 0; wr(POL, 32'hFFFF_FFFF);
    rd(STAT, v); check("R6 active-low default", v, 32'hFFFF_FFFF);
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, v); check("R3 all-ones clear", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(ENAB, 32'h1234_5678); rd(ENAB, v); check("R2 enable readback", v, 32'h1234_5678);
    wr(CRIT, 32'hA5A5_0F0F); rd(CRIT, v); check("R2 route readback", v, 32'hA5A5_0F0F);
    wr(TRIG, 32'h0000_FFFF); rd(TRIG, v); check("R2 trigger readback", v, 32'h0000_FFFF);
    wr(MASK, 32'hFFFF_FFFF);
    rd(MASK, v); check("R2 masked read-only", v, 0);
    rd(ENAB, v); check("R2 write to masked ignored", v, 32'h1234_5678);
    rd(3'd7, v); check("R2 unmapped reads zero", v, 0);
    rd(3'd6, v); check("R2 unmapped 6 reads zero", v, 0);
    cfg(0, 0, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    cfg(32'h8000_0000, 0, 32'hFFFF_FFFF, 0);
    irq[31] = 1;  // source 0
    step();
    rd(STAT, v); check("R2 source 0 is bit 31", v, 32'h8000_0000);
    step();
    check("R8 irq_o after one cycle", {31'b0, c_irq}, 1);
    wr(STAT, 32'h8000_0000);
    rd(STAT, v); check("R4 clear while active has no effect", v, 32'h8000_0000);
    irq[31] = 0;
    wr(STAT, 32'h8000_0000);
    rd(STAT, v); check("R3 clear after release", v, 0);
    step();
    check("R8 irq_o drops", {31'b0, c_irq}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    cfg(32'h0400_0000, 0, 32'hFFFF_FFFF, 32'h0400_0000);
    irq[26] = 1; step(); irq[26] = 0; step();
    rd(STAT, v); check("R5 edge pending sticky", v, 32'h0400_0000);
    check("R5 edge raises irq_o", {31'b0, c_irq}, 1);
    wr(STAT, 32'h0400_0000);
    rd(STAT, v); check("R3 edge clear", v, 0);
    irq[26] = 1;
    wr(STAT, 32'h0400_0000);
    rd(STAT, v); check("R9 set wins over clear", v, 32'h0400_0000);
    wr(STAT, 32'h0400_0000); step();
    rd(STAT, v); check("R5 steady level no retrigger", v, 0);
    irq[26] = 0;
    cfg(0, 0, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    irq[22] = 1;
    cfg(0, 0, 32'hFF3F_FFFF, 32'h0080_0000);
    rd(STAT, v); check("R6 idle after config", v, 0);
    irq[23] = 1; step();
    rd(STAT, v); check("R6 rising ignored on falling source", v, 0);
    irq[23] = 0; step();
    rd(STAT, v); check("R6 falling edge sets", v, 32'h0080_0000);
    irq[22] = 0; step();
    rd(STAT, v); check("R6 active-low level sets", v, 32'h00C0_0000);
    cfg(0, 0, 32'hFFFF_FFFF, 0);
    rd(STAT, v); check("R3 cleared after polarity test", v, 0);
  endtask

  task automatic t_mask_route();
    logic [31:0] v;
    irq[21] = 1; step();
    rd(STAT, v); check("R7 disabled source latches", v, 32'h0020_0000);
    rd(MASK, v); check("R7 masked zero when disabled", v, 0);
    step();
    check("R7 no output when disabled", {30'b0, c_irq, c_crit}, 0);
    wr(ENAB, 32'h0020_0000);
    rd(MASK, v); check("R7 masked = pending & enable", v, 32'h0020_0000);
    step();
    check("R8 normal route", {30'b0, c_irq, c_crit}, 2'b10);
    wr(CRIT, 32'h0020_0000);
    check("R8 route change registered", {30'b0, c_irq, c_crit}, 2'b10);
    step();
    check("R8 critical route", {30'b0, c_irq, c_crit}, 2'b01);
    irq[21] = 0;
    cfg(0, 0, 32'hFFFF_FFFF, 0);
    step();
    check("R8 both low after clear", {30'b0, c_irq, c_crit}, 0);
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    pwr(TRIG, 32'h8000_0000); pwr(POL, 32'h8000_0000);
    pwr(STAT, 32'hFFFF_FFFF); pwr(ENAB, 32'h8000_0000);
    prd(STAT, v); check("R10 parent idle", v, 0);
    cfg(32'h1000_0000, 0, 32'hFFFF_FFFF, 0);
    irq[28] = 1;
    step(4);
    prd(STAT, v); check("R10 parent cascade bit pending", v, 32'h8000_0000);
    check("R10 parent irq_o", {31'b0, p_irq}, 1);
    irq[28] = 0;
    wr(STAT, 32'h1000_0000);
    step(2);
    check("R10 child irq_o dropped", {31'b0, c_irq}, 0);
    check("R10 parent still asserted", {31'b0, p_irq}, 1);
    pwr(STAT, 32'h8000_0000);
    step();
    check("R10 parent drops after own ack", {31'b0, p_irq}, 0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_polarity();
    t_mask_route();
    t_cascade();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule